// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block keeps the coherence state of every line of a small direct-mapped cache whose lines hold one data word each. It has a processor port and a bus port. The processor port takes read and write requests through a valid/ready handshake and returns one response per request. The bus port issues read, read-for-ownership and write-back transactions. It samples the wired-OR shared signal while its own read is on the bus. It also watches the transactions that other caches put on the bus and answers them with the shared signal or with a flush of dirty data.

Each line is in one of four states. Invalid means no copy is held. Shared means a clean copy that other caches may also hold. Exclusive means the only copy, clean, with memory up to date. Modified means the only copy, dirty, with memory stale. Bus arbitration, the memory and the choice of victim are outside the block. The victim is always the line at the request's index. A bus transaction takes one cycle: it completes in the cycle where the block's request and the grant are both high. In that same cycle the transaction is shown to every other cache on its snoop inputs, and those caches answer combinationally.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `req_ready` is high, and `mst_valid` and `rsp_valid` are low. The first access to any address is therefore a miss.
- R2: A read miss issues a read transaction (`mst_cmd` = 1). The response carries the data returned on the bus. The line is installed as Shared if `bus_shared_in` was high in the grant cycle, and as Exclusive otherwise.
- R3: A read that hits a valid line makes no bus request. Its response, carrying the stored word, appears in the cycle after acceptance.
- R4: A write miss issues a read-for-ownership transaction (`mst_cmd` = 2) and installs the line as Modified with the written word. Every write response carries the written word.
- R5: A write that hits an Exclusive or Modified line makes no bus request, answers in the cycle after acceptance and leaves the line Modified.
- R6: A write that hits a Shared line issues a read-for-ownership before it completes, which invalidates every other copy. The line then becomes Modified.
- R7: For a snooped read to a line held here, the block raises `snp_shared` and the line becomes Shared. If the line was Modified, the block also raises `snp_flush` and puts the dirty word on `snp_fdata`.
- R8: For a snooped read-for-ownership to a line held here, the line becomes Invalid, and `snp_flush` is raised only if the line was Modified. A snooped write-back (`snp_cmd` = 3) raises neither `snp_shared` nor `snp_flush`.
- R9: A miss whose index holds a Modified line with another tag first issues a write-back (`mst_cmd` = 3) of that line's address and word, then issues the fetch. A clean victim is dropped with no write-back.
- R10: `req_ready` stays low while a bus transaction of this block is outstanding. The response follows acceptance by one cycle plus one cycle for each bus transaction, provided every request is granted at once.
- R11: In a cycle where `snp_valid` is high, `req_ready` is low, so a snoop is applied before any new processor request is looked up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low log2(LINES) bits select the line |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data, or the written word for a write |
| mst_valid | output | 1 | Bus transaction requested |
| mst_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| mst_addr | output | ADDR_W | Transaction address |
| mst_wdata | output | DATA_W | Write-back data |
| mst_grant | input | 1 | Transaction takes place this cycle |
| bus_rdata | input | DATA_W | Line data returned for a read or read-for-ownership |
| bus_shared_in | input | 1 | Wired-OR shared signal from other caches |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction, same coding as mst_cmd |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_shared | output | 1 | This cache holds the snooped line (reads only) |
| snp_flush | output | 1 | This cache supplies dirty data for the snooped line |
| snp_fdata | output | DATA_W | Flushed data |

## Verification
The bench builds two instances with ADDR_W = 6, DATA_W = 16 and LINES = 4, so sixteen test addresses fold onto four indices with four tags each. With so few lines, victim eviction, dirty write-back and cross-cache sharing all occur within a few dozen operations. A directed sequence steps through every state transition. One case starts a processor write on a line in the same cycle as the peer's read of that line, which exercises the snoop-first rule. A pseudo-random stream over the same sixteen addresses then checks the bus transactions and the response data against a behavioural model of both caches and the memory.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_EXC = 2'd2,
      LS_MOD = 2'd3
   } lstate_t;

   typedef enum logic [1:0] {
      BC_NONE = 2'd0,
      BC_RD   = 2'd1,
      BC_RDX  = 2'd2,
      BC_WB   = 2'd3
   } bcmd_t;

   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_BUS  = 1'b1
   } fsm_t;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
   import coh_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(LINES)-1:0] a_idx,
   output lstate_t                  a_st,
   output logic [TAG_W-1:0]         a_tag,
   output logic [DATA_W-1:0]        a_data,
   input  logic [$clog2(LINES)-1:0] b_idx,
   output lstate_t                  b_st,
   output logic [TAG_W-1:0]         b_tag,
   output logic [DATA_W-1:0]        b_data,
   input  logic                     st_we,
   input  logic [$clog2(LINES)-1:0] st_idx,
   input  lstate_t                  st_val,
   input  logic                     fl_we,
   input  logic [$clog2(LINES)-1:0] fl_idx,
   input  lstate_t                  fl_st,
   input  logic [TAG_W-1:0]         fl_tag,
   input  logic [DATA_W-1:0]        fl_data
);
   localparam int IDX_W = $clog2(LINES);

   lstate_t            st_q   [LINES];
   logic [TAG_W-1:0]   tag_q  [LINES];
   logic [DATA_W-1:0]  data_q [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      lstate_t           st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] data_r;

      always_ff @(posedge clk) begin
         if (!rst_n)
            st_r <= LS_INV;
         else if (fl_we && fl_idx == IDX_W'(g))
            st_r <= fl_st;
         else if (st_we && st_idx == IDX_W'(g))
            st_r <= st_val;
      end

      always_ff @(posedge clk) begin
         if (fl_we && fl_idx == IDX_W'(g)) begin
            tag_r  <= fl_tag;
            data_r <= fl_data;
         end
      end

      assign st_q[g]   = st_r;
      assign tag_q[g]  = tag_r;
      assign data_q[g] = data_r;
   end

   assign a_st   = st_q[a_idx];
   assign a_tag  = tag_q[a_idx];
   assign a_data = data_q[a_idx];
   assign b_st   = st_q[b_idx];
   assign b_tag  = tag_q[b_idx];
   assign b_data = data_q[b_idx];

endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
   import coh_pkg::*;
#(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic              snp_valid,
   input  bcmd_t             snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  lstate_t           line_st,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [DATA_W-1:0] line_data,
   output logic              shared_o,
   output logic              flush_o,
   output logic [DATA_W-1:0] fdata_o,
   output logic              upd_o,
   output lstate_t           nxt_o
);
   logic held;
   logic acts;

   always_comb begin
      held     = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);
      acts     = held && (snp_cmd == BC_RD || snp_cmd == BC_RDX);
      shared_o = held && (snp_cmd == BC_RD);
      flush_o  = acts && (line_st == LS_MOD);
      fdata_o  = line_data;
      upd_o    = acts;
      nxt_o    = (snp_cmd == BC_RD) ? LS_SHR : LS_INV;
   end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
   import coh_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int LINES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mst_valid,
   output logic [1:0]        mst_cmd,
   output logic [ADDR_W-1:0] mst_addr,
   output logic [DATA_W-1:0] mst_wdata,
   input  logic              mst_grant,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_shared_in,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_flush,
   output logic [DATA_W-1:0] snp_fdata
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed log2(LINES)");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   fsm_t              fsm_q;
   logic              pw_q;
   logic [ADDR_W-1:0] pa_q;
   logic [DATA_W-1:0] pd_q;
   logic              rsp_v_q;
   logic [DATA_W-1:0] rsp_d_q;

   logic [ADDR_W-1:0] cur_addr;
   logic [IDX_W-1:0]  cur_idx;
   logic [TAG_W-1:0]  cur_tag;
   lstate_t           c_st;
   logic [TAG_W-1:0]  c_tag;
   logic [DATA_W-1:0] c_data;
   lstate_t           s_st;
   logic [TAG_W-1:0]  s_tag;
   logic [DATA_W-1:0] s_data;
   logic              s_upd;
   lstate_t           s_nxt;
   logic              c_match;
   logic              quick_hit;
   logic              accept;
   logic              xfer;
   bcmd_t             nc;
   logic              st_we;
   logic [IDX_W-1:0]  st_idx;
   lstate_t           st_val;
   logic              fl_we;
   lstate_t           fl_st;
   logic [DATA_W-1:0] fl_data;

   assign cur_addr  = (fsm_q == FS_IDLE) ? req_addr : pa_q;
   assign cur_idx   = cur_addr[IDX_W-1:0];
   assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];
   assign c_match   = (c_st != LS_INV) && (c_tag == cur_tag);
   assign quick_hit = c_match && (!req_write || c_st == LS_EXC || c_st == LS_MOD);
   assign req_ready = (fsm_q == FS_IDLE) && !snp_valid;
   assign accept    = req_valid && req_ready;

   always_comb begin
      if (fsm_q != FS_BUS)     nc = BC_NONE;
      else if (c_match)        nc = BC_RDX;
      else if (c_st == LS_MOD) nc = BC_WB;
      else if (pw_q)           nc = BC_RDX;
      else                     nc = BC_RD;
   end

   assign mst_valid = (fsm_q == FS_BUS);
   assign mst_cmd   = nc;
   assign mst_addr  = (nc == BC_WB) ? {c_tag, cur_idx} : pa_q;
   assign mst_wdata = c_data;
   assign xfer      = mst_valid && mst_grant;

   always_comb begin
      fl_we   = (accept && req_write && quick_hit) || (xfer && nc != BC_WB);
      fl_st   = LS_MOD;
      fl_data = pd_q;
      if (accept) begin
         fl_data = req_wdata;
      end else if (nc == BC_RD) begin
         fl_data = bus_rdata;
         fl_st   = bus_shared_in ? LS_SHR : LS_EXC;
      end
      st_we  = s_upd || (xfer && nc == BC_WB);
      st_idx = s_upd ? snp_addr[IDX_W-1:0] : cur_idx;
      st_val = s_upd ? s_nxt : LS_INV;
   end

   coh_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_idx   (cur_idx),
      .a_st    (c_st),
      .a_tag   (c_tag),
      .a_data  (c_data),
      .b_idx   (snp_addr[IDX_W-1:0]),
      .b_st    (s_st),
      .b_tag   (s_tag),
      .b_data  (s_data),
      .st_we   (st_we),
      .st_idx  (st_idx),
      .st_val  (st_val),
      .fl_we   (fl_we),
      .fl_idx  (cur_idx),
      .fl_st   (fl_st),
      .fl_tag  (cur_tag),
      .fl_data (fl_data)
   );

   coh_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .snp_valid (snp_valid),
      .snp_cmd   (bcmd_t'(snp_cmd)),
      .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
      .line_st   (s_st),
      .line_tag  (s_tag),
      .line_data (s_data),
      .shared_o  (snp_shared),
      .flush_o   (snp_flush),
      .fdata_o   (snp_fdata),
      .upd_o     (s_upd),
      .nxt_o     (s_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q   <= FS_IDLE;
         pw_q    <= 1'b0;
         pa_q    <= '0;
         pd_q    <= '0;
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         if (fsm_q == FS_IDLE) begin
            if (accept) begin
               if (quick_hit) begin
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= req_write ? req_wdata : c_data;
               end else begin
                  fsm_q <= FS_BUS;
                  pw_q  <= req_write;
                  pa_q  <= req_addr;
                  pd_q  <= req_wdata;
               end
            end
         end else if (xfer && nc != BC_WB) begin
            fsm_q   <= FS_IDLE;
            rsp_v_q <= 1'b1;
            rsp_d_q <= (nc == BC_RD) ? bus_rdata : pd_q;
         end
      end
   end

   assign rsp_valid = rsp_v_q;
   assign rsp_rdata = rsp_d_q;

   // R10: no new request while a bus transaction is outstanding
   p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_q == FS_BUS) |-> !req_ready);

   // R11: a snoop cycle never accepts a processor request
   p_snoop_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !req_ready);

   // R3: a read hit answers next cycle without the bus
   p_read_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_write && c_match) |=> (rsp_valid && !mst_valid));

   // R5: a write to an Exclusive line is silent
   p_exc_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_write && c_match && c_st == LS_EXC) |=> (rsp_valid && !mst_valid));

   // R4: read-for-ownership completes the request
   p_rdx_completes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && mst_cmd == BC_RDX) |=> (rsp_valid && fsm_q == FS_IDLE));

   // R9: a write-back is always followed by the fetch
   p_fill_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && mst_cmd == BC_WB) |=> (mst_valid && mst_cmd != BC_WB));

   // R8: snooped write-backs draw no response
   p_wb_snoop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd == BC_WB) |-> !(snp_shared || snp_flush));

   // R7: the flush answers only a live snoop
   p_flush_needs_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> snp_valid);

endmodule

// File: tb/coh_line_ctrl_bench.sv
module coh_line_ctrl_bench;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam int NL = 4;
   localparam int CRD = 1, CRDX = 2, CWB = 3;
   localparam int SI = 0, SS = 1, SE = 2, SM = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          rq_valid [2];
   logic          rq_ready [2];
   logic          rq_write [2];
   logic [AW-1:0] rq_addr  [2];
   logic [DW-1:0] rq_wdata [2];
   logic          rs_valid [2];
   logic [DW-1:0] rs_rdata [2];
   logic          mv  [2];
   logic [1:0]    mcmd[2];
   logic [AW-1:0] madr[2];
   logic [DW-1:0] mwd [2];
   logic          gnt [2];
   logic [DW-1:0] brd [2];
   logic          bsh [2];
   logic          sv  [2];
   logic [1:0]    scmd[2];
   logic [AW-1:0] sadr[2];
   logic          ssh [2];
   logic          sfl [2];
   logic [DW-1:0] sfd [2];
   logic [DW-1:0] bmem [64];

   int nchecks = 0;
   int nerr = 0;

   assign gnt[0]  = mv[0];
   assign gnt[1]  = mv[1] && !mv[0];
   assign sv[1]   = gnt[0];
   assign scmd[1] = mcmd[0];
   assign sadr[1] = madr[0];
   assign sv[0]   = gnt[1];
   assign scmd[0] = mcmd[1];
   assign sadr[0] = madr[1];
   assign brd[0]  = sfl[1] ? sfd[1] : bmem[madr[0]];
   assign brd[1]  = sfl[0] ? sfd[0] : bmem[madr[1]];
   assign bsh[0]  = ssh[1];
   assign bsh[1]  = ssh[0];

   always @(posedge clk) begin
      for (int c = 0; c < 2; c++) begin
         if (gnt[c]) begin
            if (mcmd[c] == 2'(CWB)) bmem[madr[c]] <= mwd[c];
            if (sfl[1-c]) bmem[madr[c]] <= sfd[1-c];
         end
      end
   end

   coh_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_coh_line_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(rq_valid[0]), .req_ready(rq_ready[0]), .req_write(rq_write[0]),
      .req_addr(rq_addr[0]), .req_wdata(rq_wdata[0]),
      .rsp_valid(rs_valid[0]), .rsp_rdata(rs_rdata[0]),
      .mst_valid(mv[0]), .mst_cmd(mcmd[0]), .mst_addr(madr[0]), .mst_wdata(mwd[0]),
      .mst_grant(gnt[0]), .bus_rdata(brd[0]), .bus_shared_in(bsh[0]),
      .snp_valid(sv[0]), .snp_cmd(scmd[0]), .snp_addr(sadr[0]),
      .snp_shared(ssh[0]), .snp_flush(sfl[0]), .snp_fdata(sfd[0]));

   coh_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_coh_line_ctrl_peer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(rq_valid[1]), .req_ready(rq_ready[1]), .req_write(rq_write[1]),
      .req_addr(rq_addr[1]), .req_wdata(rq_wdata[1]),
      .rsp_valid(rs_valid[1]), .rsp_rdata(rs_rdata[1]),
      .mst_valid(mv[1]), .mst_cmd(mcmd[1]), .mst_addr(madr[1]), .mst_wdata(mwd[1]),
      .mst_grant(gnt[1]), .bus_rdata(brd[1]), .bus_shared_in(bsh[1]),
      .snp_valid(sv[1]), .snp_cmd(scmd[1]), .snp_addr(sadr[1]),
      .snp_shared(ssh[1]), .snp_flush(sfl[1]), .snp_fdata(sfd[1]));

   // behavioural reference: states, tags, words of both caches and memory
   int m_st  [2][NL];
   int m_tag [2][NL];
   int m_dat [2][NL];
   int m_mem [64];

   typedef struct {
      int master; int cmd; int addr; int wdata; int shared; int flush;
   } trx_t;
   trx_t exq[$];

   task automatic chk(bit ok, string rq, string what, int act, int exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic void model_op(int c, bit w, int a, int d,
                                    output int rdata, output int ntr);
      int o, idx, tg, fd;
      bit hit, ohit, ofl;
      trx_t t;
      o = 1 - c; idx = a % NL; tg = a / NL; ntr = 0;
      hit = (m_st[c][idx] != SI) && (m_tag[c][idx] == tg);
      if (hit && !w) begin
         rdata = m_dat[c][idx];
         return;
      end
      if (hit && w && m_st[c][idx] >= SE) begin
         m_st[c][idx] = SM; m_dat[c][idx] = d; rdata = d;
         return;
      end
      if (!hit && m_st[c][idx] == SM) begin
         t = '{c, CWB, m_tag[c][idx] * NL + idx, m_dat[c][idx], 0, 0};
         exq.push_back(t);
         m_mem[m_tag[c][idx] * NL + idx] = m_dat[c][idx];
         m_st[c][idx] = SI;
         ntr++;
      end
      ohit = (m_st[o][idx] != SI) && (m_tag[o][idx] == tg);
      ofl  = ohit && (m_st[o][idx] == SM);
      fd   = m_dat[o][idx];
      if (ofl) m_mem[a] = fd;
      if (!w) begin
         t = '{c, CRD, a, 0, int'(ohit), int'(ofl)};
         rdata = m_mem[a];
         if (ohit) m_st[o][idx] = SS;
         m_st[c][idx] = ohit ? SS : SE;
         m_dat[c][idx] = rdata;
      end else begin
         t = '{c, CRDX, a, 0, 0, int'(ofl)};
         if (ohit) m_st[o][idx] = SI;
         m_st[c][idx] = SM;
         m_dat[c][idx] = d;
         rdata = d;
      end
      m_tag[c][idx] = tg;
      exq.push_back(t);
      ntr++;
   endfunction

   // every clock: compare each granted transaction with the model's list
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < 2; c++) begin
            if (gnt[c]) begin
               if (exq.size() == 0) begin
                  chk(1'b0, "R2 R4 R6 R9", "unexpected bus cmd", int'(mcmd[c]), 0);
               end else begin
                  trx_t e;
                  e = exq.pop_front();
                  chk(e.master == c, "R10", "bus master", c, e.master);
                  chk(int'(mcmd[c]) == e.cmd, "R2 R4 R6 R9", "bus cmd", int'(mcmd[c]), e.cmd);
                  chk(int'(madr[c]) == e.addr, "R2 R4 R9", "bus addr", int'(madr[c]), e.addr);
                  if (e.cmd == CWB)
                     chk(int'(mwd[c]) == e.wdata, "R9", "write-back data", int'(mwd[c]), e.wdata);
                  chk(int'(ssh[1-c]) == e.shared, "R7 R8", "shared", int'(ssh[1-c]), e.shared);
                  chk(int'(sfl[1-c]) == e.flush, "R7 R8", "flush", int'(sfl[1-c]), e.flush);
               end
            end
         end
      end
   end

   task automatic run_op(int c, bit w, int a, int d, int exp_r, int ntr,
                         int delay, string rq, output int nwait);
      int lat;
      bit rdy;
      nwait = 0;
      repeat (delay) @(negedge clk);
      rq_valid[c] = 1'b1;
      rq_write[c] = w;
      rq_addr[c]  = AW'(a);
      rq_wdata[c] = DW'(d);
      forever begin
         #1;
         rdy = rq_ready[c];
         @(posedge clk);
         if (rdy) break;
         nwait++;
         @(negedge clk);
      end
      @(negedge clk);
      rq_valid[c] = 1'b0;
      lat = 1;
      while (!rs_valid[c] && lat < 40) begin
         lat++;
         @(negedge clk);
      end
      chk(lat == 1 + ntr, rq, "latency R10", lat, 1 + ntr);
      chk(int'(rs_rdata[c]) == exp_r, rq, "response data", int'(rs_rdata[c]), exp_r);
   endtask

   task automatic op(int c, bit w, int a, int d, string rq);
      int er, nt, nw;
      model_op(c, w, a, d & 16'hFFFF, er, nt);
      run_op(c, w, a, d & 16'hFFFF, er, nt, 0, rq, nw);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   end

   initial begin
      int er0, er1, nt0, nt1, nw0, nw1;
      int unsigned lf;
      for (int i = 0; i < 64; i++) begin
         bmem[i]  = DW'(i * 37 + 5);
         m_mem[i] = (i * 37 + 5) & 16'hFFFF;
      end
      for (int c = 0; c < 2; c++) begin
         rq_valid[c] = 1'b0; rq_write[c] = 1'b0; rq_addr[c] = '0; rq_wdata[c] = '0;
         for (int k = 0; k < NL; k++) begin
            m_st[c][k] = SI; m_tag[c][k] = 0; m_dat[c][k] = 0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
         chk(rq_ready[c] == 1'b1, "R1", "ready after reset", int'(rq_ready[c]), 1);
         chk(mv[c] == 1'b0, "R1", "bus idle after reset", int'(mv[c]), 0);
         chk(rs_valid[c] == 1'b0, "R1", "no response after reset", int'(rs_valid[c]), 0);
      end

      op(0, 0, 5, 0, "R1 R2");          // miss, installs Exclusive
      op(0, 0, 5, 0, "R3");             // read hit
      op(0, 1, 5, 16'h1111, "R5");      // Exclusive -> Modified, silent
      op(0, 1, 5, 16'h2222, "R5");      // Modified write hit
      op(1, 0, 5, 0, "R7");             // peer flushes, both Shared
      op(0, 1, 5, 16'h3333, "R6");      // Shared write upgrade
      op(1, 0, 5, 0, "R7");             // flush from Modified
      op(1, 1, 5, 16'h4444, "R8");      // invalidate Shared copy, no flush
      op(1, 0, 13, 0, "R9");            // dirty victim written back
      op(0, 0, 5, 0, "R2");             // sees written-back word
      op(0, 1, 21, 16'h5555, "R4 R9");  // clean victim dropped
      op(0, 0, 37, 0, "R9");            // dirty victim then fetch
      op(1, 1, 2, 16'h6666, "R4");
      op(0, 0, 2, 0, "R7");

      // R11: peer read of 37 and local write of 37 one cycle apart
      model_op(1, 0, 37, 0, er1, nt1);
      model_op(0, 1, 37, 16'h7777, er0, nt0);
      fork
         run_op(1, 0, 37, 0, er1, nt1, 0, "R7", nw1);
         run_op(0, 1, 37, 16'h7777, er0, nt0, 1, "R11 R6", nw0);
      join
      chk(nw0 == 1, "R11", "cycles held off by snoop", nw0, 1);

      lf = 32'h1234_5678;
      for (int n = 0; n < 80; n++) begin
         lf = lf * 32'd1103515245 + 32'd12345;
         op(int'(lf[20]), lf[21], int'(lf[27:24]), int'(lf[15:0]), "R2 R4 R6 R7 R8");
      end

      repeat (3) @(negedge clk);
      chk(exq.size() == 0, "R10", "missing bus transactions", exq.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   end

endmodule